// File: doc/BRIEF.md
# Two-Channel Software-Commanded DMA Engine

This block moves data between memory locations on behalf of software. It owns two independent channels, each configured through a small register port with a control word, a starting source address, a starting destination address and an item count. Software starts, pauses, resumes and cancels each channel by writing a 2-bit command inside the control word. Every item is read from the current source address into a holding register, then written to the current destination address, over one shared request/grant memory master port.

While a channel runs, its current source, destination and count registers can be read back to follow its progress. When the count runs out, the channel either stops or, with auto-reload enabled, restarts from its initial values. A completion flag is raised if the channel's interrupt enable is set. A failed memory access stops the channel, raises a flag for the read or write side, and records the faulting address and direction. When both channels are active, the memory port alternates between them after each channel has finished its burst.

Top module: `dual_dma_engine`

## Requirements
- R1: A control write (word index 8*ch) stores bits 14, 12, 10:9, 6:5 and 2:1 and reads back 0 in the other bits. Start (command bits 4:3 = 1) on an idle channel copies the initial source, destination and count into the current registers and sets the channel's busy bit. Start is ignored when the initial count is 0. A control write whose width field (bits 2:1) is 3 changes nothing.
- R2: Each item is one read of mem_size = width code (0 byte, 1 halfword, 2 word) at the current source, then one write at the current destination. The write data equals the read data masked to the item width.
- R3: After a read the current source grows by the item size in bytes (1, 2 or 4), unless bit 6 is 1 (fixed). After a write the current destination does the same, unless bit 5 is 1 (fixed).
- R4: The current count drops by one per written item. When it reaches 0 the busy bit clears, and status bit ch is set only if bit 12 of the control word is 1.
- R5: With bit 14 set, finishing the count reloads all three current registers from the initial ones, and the channel stays busy.
- R6: Pause (command 2) stops all memory traffic of a busy channel and freezes its current registers. A following start resumes without reloading. Cancel (command 3) clears busy and does not set the completion flag.
- R7: The interrupt output mirrors a 4-bit status register (word index 16). Writing 1 to a bit clears it, writing 0 leaves it. A new event in the same cycle wins over the clear.
- R8: A granted access with mem_err set stops the channel and leaves its current registers unadvanced. It sets status bit 2 for a read or bit 3 for a write, stores the address at word index 8*ch+7, and stores the direction (1 = write) in bit ch of word index 18.
- R9: Burst code bits 10:9 (0/1/2/3 = 1/4/8/16 items) sets how many items a channel completes before the port passes to the other busy channel.
- R10: A request that is not granted keeps the same address and direction on the next cycle.
- R11: After reset no request is made, the interrupt output is 0 and all registers read 0.
- R12: Word indices 8*ch+1..3 hold the initial source, destination and 16-bit count, and 8*ch+4..6 the current ones. Word index 17 shows busy per channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Access accepted and completed this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Item width code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with the grant |
| mem_err | input | 1 | Access failed, valid with the grant |
| irq | output | 4 | Status flags: done ch0, done ch1, read error, write error |

## Verification
The hardest situations to reach are commands that land between the read and the write of one item, and arbitration hand-overs while grants are withheld. A paused channel then carries held data, and the burst counter must restart for the other owner. The stimulus reaches them with pseudo-random grant gaps and pause/cancel writes at fixed cycle offsets into a running transfer. A behavioural model checks the memory port and the flags on every clock. Address windows that return errors cover both fault directions.

// File: rtl/dual_dma_engine.sv
module dual_dma_engine #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  output logic [3:0]        irq
);
  localparam int NCH = 2;
  localparam int BW  = 5;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_5666;
  localparam logic [4:0]  A_STS  = 5'd16;
  localparam logic [4:0]  A_BUSY = 5'd17;
  localparam logic [4:0]  A_EDIR = 5'd18;

  logic [31:0]       ctrl_q [NCH];
  logic [31:0]       hold_q [NCH];
  logic [ADDR_W-1:0] isrc_q [NCH];
  logic [ADDR_W-1:0] idst_q [NCH];
  logic [ADDR_W-1:0] csrc_q [NCH];
  logic [ADDR_W-1:0] cdst_q [NCH];
  logic [ADDR_W-1:0] eaddr_q[NCH];
  logic [CNT_W-1:0]  icnt_q [NCH];
  logic [CNT_W-1:0]  ccnt_q [NCH];
  logic [NCH-1:0]    busy_q, pause_q, phase_q, edir_q, run;
  logic [3:0]        sts_q, sts_set, sts_clr;
  logic              own_q, eff;
  logic [BW-1:0]     beats_q, blen, nxt_beats;
  logic [1:0]        wsel;
  logic [ADDR_W-1:0] step;
  logic              fire, ok, bad, item_done, last;

  function automatic logic [31:0] lane_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  assign run       = busy_q & ~pause_q;
  assign eff       = (!run[own_q] && run[!own_q]) ? !own_q : own_q;
  assign wsel      = ctrl_q[eff][2:1];
  assign step      = ADDR_W'(1) << wsel;
  assign mem_req   = run[eff];
  assign mem_we    = phase_q[eff];
  assign mem_addr  = phase_q[eff] ? cdst_q[eff] : csrc_q[eff];
  assign mem_size  = wsel;
  assign mem_wdata = hold_q[eff];
  assign fire      = mem_req & mem_gnt;
  assign ok        = fire & ~mem_err;
  assign bad       = fire & mem_err;
  assign item_done = ok & phase_q[eff];
  assign last      = item_done && (ccnt_q[eff] == CNT_W'(1));
  assign nxt_beats = ((eff == own_q) ? beats_q : '0) + BW'(1);
  assign irq       = sts_q;

  assign sts_set[0] = last && ctrl_q[eff][12] && !eff;
  assign sts_set[1] = last && ctrl_q[eff][12] && eff;
  assign sts_set[2] = bad && !mem_we;
  assign sts_set[3] = bad && mem_we;
  assign sts_clr    = (reg_we && reg_addr == A_STS) ? reg_wdata[3:0] : 4'h0;

  always_comb begin
    case (ctrl_q[eff][10:9])
      2'd0:    blen = BW'(1);
      2'd1:    blen = BW'(4);
      2'd2:    blen = BW'(8);
      default: blen = BW'(16);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        ctrl_q[c]  <= '0;
        hold_q[c]  <= '0;
        isrc_q[c]  <= '0;
        idst_q[c]  <= '0;
        csrc_q[c]  <= '0;
        cdst_q[c]  <= '0;
        eaddr_q[c] <= '0;
        icnt_q[c]  <= '0;
        ccnt_q[c]  <= '0;
      end
      busy_q  <= '0;
      pause_q <= '0;
      phase_q <= '0;
      edir_q  <= '0;
      sts_q   <= '0;
      own_q   <= 1'b0;
      beats_q <= '0;
    end else begin
      if (ok && !phase_q[eff]) begin
        hold_q[eff]  <= mem_rdata & lane_mask(wsel);
        phase_q[eff] <= 1'b1;
        if (!ctrl_q[eff][6]) csrc_q[eff] <= csrc_q[eff] + step;
      end

      if (item_done) begin
        phase_q[eff] <= 1'b0;
        if (!ctrl_q[eff][5]) cdst_q[eff] <= cdst_q[eff] + step;
        ccnt_q[eff] <= ccnt_q[eff] - CNT_W'(1);
        if (last) begin
          if (ctrl_q[eff][14] && icnt_q[eff] != '0) begin
            csrc_q[eff] <= isrc_q[eff];
            cdst_q[eff] <= idst_q[eff];
            ccnt_q[eff] <= icnt_q[eff];
          end else begin
            busy_q[eff] <= 1'b0;
          end
        end
        if (nxt_beats >= blen) begin
          beats_q <= '0;
          own_q   <= run[!eff] ? !eff : eff;
        end else begin
          beats_q <= nxt_beats;
          own_q   <= eff;
        end
      end else if (eff != own_q) begin
        own_q   <= eff;
        beats_q <= '0;
      end

      if (bad) begin
        busy_q[eff]  <= 1'b0;
        pause_q[eff] <= 1'b0;
        phase_q[eff] <= 1'b0;
        eaddr_q[eff] <= mem_addr;
        edir_q[eff]  <= mem_we;
      end

      sts_q <= (sts_q & ~sts_clr) | sts_set;

      for (int c = 0; c < NCH; c++) begin
        if (reg_we && reg_addr == 5'(c*8) && reg_wdata[2:1] != 2'd3) begin
          ctrl_q[c] <= reg_wdata & CTRL_KEEP;
          case (reg_wdata[4:3])
            2'd1: begin
              if (!busy_q[c]) begin
                if (icnt_q[c] != '0) begin
                  busy_q[c]  <= 1'b1;
                  pause_q[c] <= 1'b0;
                  phase_q[c] <= 1'b0;
                  csrc_q[c]  <= isrc_q[c];
                  cdst_q[c]  <= idst_q[c];
                  ccnt_q[c]  <= icnt_q[c];
                end
              end else if (pause_q[c]) begin
                pause_q[c] <= 1'b0;
              end
            end
            2'd2: if (busy_q[c]) pause_q[c] <= 1'b1;
            2'd3: begin
              busy_q[c]  <= 1'b0;
              pause_q[c] <= 1'b0;
              phase_q[c] <= 1'b0;
            end
            default: ;
          endcase
        end
        if (reg_we && reg_addr == 5'(c*8+1)) isrc_q[c] <= reg_wdata[ADDR_W-1:0];
        if (reg_we && reg_addr == 5'(c*8+2)) idst_q[c] <= reg_wdata[ADDR_W-1:0];
        if (reg_we && reg_addr == 5'(c*8+3)) icnt_q[c] <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == 5'(c*8))   reg_rdata = ctrl_q[c];
      if (reg_addr == 5'(c*8+1)) reg_rdata = 32'(isrc_q[c]);
      if (reg_addr == 5'(c*8+2)) reg_rdata = 32'(idst_q[c]);
      if (reg_addr == 5'(c*8+3)) reg_rdata = 32'(icnt_q[c]);
      if (reg_addr == 5'(c*8+4)) reg_rdata = 32'(csrc_q[c]);
      if (reg_addr == 5'(c*8+5)) reg_rdata = 32'(cdst_q[c]);
      if (reg_addr == 5'(c*8+6)) reg_rdata = 32'(ccnt_q[c]);
      if (reg_addr == 5'(c*8+7)) reg_rdata = 32'(eaddr_q[c]);
    end
    if (reg_addr == A_STS)  reg_rdata = 32'(sts_q);
    if (reg_addr == A_BUSY) reg_rdata = 32'(busy_q);
    if (reg_addr == A_EDIR) reg_rdata = 32'(edir_q);
  end
endmodule

// File: rtl/dual_dma_engine_chk.sv
module dual_dma_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_err,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_size,
  input logic [1:0]        err_flags,
  input logic [1:0]        busy
);
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy != 2'b00); // R1

  AST_NO_RESERVED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !reg_we |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

  AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && mem_err |=> ($past(mem_we) ? err_flags[1] : err_flags[0])); // R8
endmodule

bind dual_dma_engine dual_dma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_err(mem_err), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
  .err_flags(irq[3:2]), .busy(busy_q)
);

// File: tb/dual_dma_engine_bench.sv
module dual_dma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic        mem_gnt = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  mem_size;
  logic [3:0]  irq;

  always #2 clk = ~clk;

  dual_dma_engine u_dual_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .irq(irq)
  );

  int errs = 0;
  int checks = 0;
  bit gnt_all = 1'b1;
  bit flt_en = 1'b0;
  logic [31:0] flt_lo = '0, flt_hi = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit rec_en = 1'b0;
  int wseq[$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ctrl[2], m_isrc[2], m_idst[2], m_csrc[2], m_cdst[2], m_hold[2], m_eaddr[2];
  logic [15:0] m_icnt[2], m_ccnt[2];
  bit m_busy[2], m_pause[2], m_phase[2], m_edir[2];
  logic [3:0] m_sts;
  int m_own, m_beats;

  function automatic bit m_run(int c);
    return m_busy[c] && !m_pause[c];
  endfunction

  function automatic int m_eff();
    return (!m_run(m_own) && m_run(1 - m_own)) ? 1 - m_own : m_own;
  endfunction

  function automatic logic [31:0] wmask(int w);
    return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 0; m_isrc[c] = 0; m_idst[c] = 0; m_csrc[c] = 0; m_cdst[c] = 0;
        m_hold[c] = 0; m_eaddr[c] = 0; m_icnt[c] = 0; m_ccnt[c] = 0;
        m_busy[c] = 0; m_pause[c] = 0; m_phase[c] = 0; m_edir[c] = 0;
      end
      m_sts = 0; m_own = 0; m_beats = 0;
    end else begin
      int e, w, stp, nb, bl;
      bit ob[2], op[2];
      logic [3:0] setv;
      e = m_eff();
      w = int'(m_ctrl[e][2:1]);
      stp = 1 << w;
      ob = m_busy; op = m_pause;
      setv = 0;
      if (m_run(e) && mem_gnt && mem_err) begin
        setv[m_phase[e] ? 3 : 2] = 1'b1;
        m_eaddr[e] = m_phase[e] ? m_cdst[e] : m_csrc[e];
        m_edir[e] = m_phase[e];
        m_busy[e] = 0; m_pause[e] = 0; m_phase[e] = 0;
        if (e != m_own) begin m_own = e; m_beats = 0; end
      end else if (m_run(e) && mem_gnt && !m_phase[e]) begin
        m_hold[e] = mem_rdata & wmask(w);
        m_phase[e] = 1;
        if (!m_ctrl[e][6]) m_csrc[e] = m_csrc[e] + stp;
        if (e != m_own) begin m_own = e; m_beats = 0; end
      end else if (m_run(e) && mem_gnt) begin
        m_phase[e] = 0;
        if (!m_ctrl[e][5]) m_cdst[e] = m_cdst[e] + stp;
        if (m_ccnt[e] == 1) begin
          if (m_ctrl[e][12]) setv[e] = 1'b1;
          if (m_ctrl[e][14] && m_icnt[e] != 0) begin
            m_csrc[e] = m_isrc[e]; m_cdst[e] = m_idst[e]; m_ccnt[e] = m_icnt[e];
          end else begin
            m_ccnt[e] = 0; m_busy[e] = 0;
          end
        end else m_ccnt[e] = m_ccnt[e] - 1;
        bl = (m_ctrl[e][10:9] == 0) ? 1 : (m_ctrl[e][10:9] == 1) ? 4 : (m_ctrl[e][10:9] == 2) ? 8 : 16;
        nb = ((e == m_own) ? m_beats : 0) + 1;
        if (nb >= bl) begin m_beats = 0; m_own = m_run(1 - e) ? 1 - e : e; end
        else begin m_beats = nb; m_own = e; end
      end else if (e != m_own) begin
        m_own = e; m_beats = 0;
      end
      m_sts = (m_sts & ~((reg_we && reg_addr == 16) ? reg_wdata[3:0] : 4'h0)) | setv;
      if (reg_we && reg_addr < 16) begin
        int c, o;
        c = int'(reg_addr) / 8; o = int'(reg_addr) % 8;
        if (o == 0 && reg_wdata[2:1] != 3) begin
          m_ctrl[c] = reg_wdata & 32'h5666;
          if (reg_wdata[4:3] == 1) begin
            if (!ob[c]) begin
              if (m_icnt[c] != 0) begin
                m_busy[c] = 1; m_pause[c] = 0; m_phase[c] = 0;
                m_csrc[c] = m_isrc[c]; m_cdst[c] = m_idst[c]; m_ccnt[c] = m_icnt[c];
              end
            end else if (op[c]) m_pause[c] = 0;
          end else if (reg_wdata[4:3] == 2) begin
            if (ob[c]) m_pause[c] = 1;
          end else if (reg_wdata[4:3] == 3) begin
            m_busy[c] = 0; m_pause[c] = 0; m_phase[c] = 0;
          end
        end
        if (o == 1) m_isrc[c] = reg_wdata;
        if (o == 2) m_idst[c] = reg_wdata;
        if (o == 3) m_icnt[c] = reg_wdata[15:0];
      end
    end
  end

  // per-cycle comparison and memory responder
  always @(negedge clk) begin
    if (rst_n) begin
      int e;
      e = m_eff();
      chk("R2", "mem_req", 32'(mem_req), 32'(m_run(e)));
      if (m_run(e) && mem_req) begin
        chk("R2", "mem_we", 32'(mem_we), 32'(m_phase[e]));
        chk("R3", "mem_addr", mem_addr, m_phase[e] ? m_cdst[e] : m_csrc[e]);
        chk("R2", "mem_size", 32'(mem_size), 32'(m_ctrl[e][2:1]));
        if (m_phase[e]) chk("R2", "mem_wdata", mem_wdata, m_hold[e]);
      end
      chk("R7", "irq", 32'(irq), 32'(m_sts));
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_gnt   = gnt_all | lfsr[0];
    mem_rdata = (mem_addr * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    mem_err   = flt_en && mem_addr >= flt_lo && mem_addr < flt_hi;
    if (rec_en && mem_req && mem_gnt && mem_we) wseq.push_back(mem_addr >= 32'h2000 ? 1 : 0);
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input int c);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(5'd17, v);
      if (!v[c]) break;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, s0, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    #1;
    chk("R11", "irq after reset", 32'(irq), 32'h0);
    chk("R11", "mem_req after reset", 32'(mem_req), 32'h0);
    rd(5'd0, v);  chk("R11", "ctrl0 after reset", v, 32'h0);
    rd(5'd17, v); chk("R11", "busy after reset", v, 32'h0);

    // R12 register readback
    wr(5'd1, 32'h0000_1000);
    wr(5'd2, 32'h0000_1800);
    wr(5'd3, 32'hABCD_0003);
    rd(5'd1, v); chk("R12", "isrc0", v, 32'h1000);
    rd(5'd2, v); chk("R12", "idst0", v, 32'h1800);
    rd(5'd3, v); chk("R12", "icnt0 16-bit", v, 32'h0003);

    // R3 R4 word, incrementing, interrupt enabled
    wr(5'd0, 32'h0000_100C);
    rd(5'd17, v); chk("R1", "busy after start", v & 32'h1, 32'h1);
    wait_idle(0);
    rd(5'd4, v); chk("R3", "csrc0 word incr", v, 32'h100C);
    rd(5'd5, v); chk("R3", "cdst0 word incr", v, 32'h180C);
    rd(5'd6, v); chk("R4", "ccnt0 done", v, 32'h0);
    chk("R4", "done flag ch0", 32'(irq), 32'h1);
    rd(5'd0, v); chk("R1", "ctrl0 stored fields", v, 32'h1004);
    wr(5'd16, 32'h1);
    chk("R7", "done flag cleared", 32'(irq), 32'h0);

    // R3 R4 byte, source fixed, no interrupt, random grant
    gnt_all = 1'b0;
    wr(5'd1, 32'h0000_1103);
    wr(5'd2, 32'h0000_1900);
    wr(5'd3, 32'h4);
    wr(5'd0, 32'h0000_0048);
    wait_idle(0);
    rd(5'd4, v); chk("R3", "csrc0 fixed", v, 32'h1103);
    rd(5'd5, v); chk("R3", "cdst0 byte incr", v, 32'h1904);
    chk("R4", "no flag without enable", 32'(irq), 32'h0);

    // R5 auto-reload, halfword
    wr(5'd1, 32'h0000_1000);
    wr(5'd2, 32'h0000_1A00);
    wr(5'd3, 32'h2);
    wr(5'd0, 32'h0000_500A);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (irq[0]) break;
    end
    chk("R5", "first completion", 32'(irq[0]), 32'h1);
    rd(5'd17, v); chk("R5", "busy after reload", v & 32'h1, 32'h1);
    // R6 cancel
    wr(5'd0, 32'h0000_501A);
    wr(5'd16, 32'h1);
    repeat (10) @(negedge clk);
    rd(5'd17, v); chk("R6", "busy after cancel", v & 32'h1, 32'h0);
    chk("R6", "no flag after cancel", 32'(irq), 32'h0);

    // R6 pause and resume
    gnt_all = 1'b1;
    wr(5'd2, 32'h0000_1C00);
    wr(5'd3, 32'd10);
    wr(5'd0, 32'h0000_100C);
    repeat (6) @(negedge clk);
    wr(5'd0, 32'h0000_1014);
    rd(5'd4, s0);
    rd(5'd6, n0);
    chk("R6", "paused midway", 32'(n0 > 0 && n0 < 10), 32'h1);
    repeat (20) @(negedge clk);
    chk("R6", "no request while paused", 32'(mem_req), 32'h0);
    rd(5'd4, v); chk("R6", "csrc frozen", v, s0);
    rd(5'd6, v); chk("R6", "ccnt frozen", v, n0);
    wr(5'd0, 32'h0000_100C);
    wait_idle(0);
    rd(5'd4, v); chk("R6", "resume without reload", v, 32'h1028);
    rd(5'd6, v); chk("R6", "resume finishes", v, 32'h0);
    chk("R6", "flag after resume", 32'(irq), 32'h1);
    wr(5'd16, 32'h1);

    // R6 cancel mid transfer
    wr(5'd0, 32'h0000_100C);
    repeat (5) @(negedge clk);
    wr(5'd0, 32'h0000_101C);
    repeat (5) @(negedge clk);
    rd(5'd17, v); chk("R6", "cancel clears busy", v, 32'h0);
    chk("R6", "cancel raises no flag", 32'(irq), 32'h0);
    rd(5'd6, v); chk("R6", "cancel leaves count", 32'(v != 0), 32'h1);

    // R1 ignored starts
    wr(5'd3, 32'h0);
    wr(5'd0, 32'h0000_100C);
    repeat (3) @(negedge clk);
    rd(5'd17, v); chk("R1", "zero count start ignored", v, 32'h0);
    wr(5'd3, 32'h5);
    wr(5'd0, 32'h0000_100E);
    repeat (3) @(negedge clk);
    rd(5'd17, v); chk("R1", "reserved width start ignored", v, 32'h0);
    rd(5'd0, v);  chk("R1", "reserved width write dropped", v, 32'h1004);

    // R9 burst arbitration
    wr(5'd1, 32'h0000_1000);
    wr(5'd2, 32'h0000_1400);
    wr(5'd3, 32'd12);
    wr(5'd9, 32'h0000_3000);
    wr(5'd10, 32'h0000_2400);
    wr(5'd11, 32'd12);
    rec_en = 1'b1;
    wr(5'd0, 32'h0000_020C);
    wr(5'd8, 32'h0000_000C);
    wait_idle(0);
    wait_idle(1);
    rec_en = 1'b0;
    begin
      int exp_seq[10] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 1};
      for (int i = 0; i < 10; i++)
        chk("R9", $sformatf("write owner %0d", i), (i < wseq.size()) ? 32'(wseq[i]) : 32'hFFFF, 32'(exp_seq[i]));
    end

    // R8 write-side fault on ch1
    flt_en = 1'b1; flt_lo = 32'h2800; flt_hi = 32'h2900;
    wr(5'd10, 32'h0000_2800);
    wr(5'd11, 32'd4);
    wr(5'd8, 32'h0000_100C);
    wait_idle(1);
    chk("R8", "write error flag", 32'(irq), 32'h8);
    rd(5'd15, v); chk("R8", "ch1 fault address", v, 32'h2800);
    rd(5'd18, v); chk("R8", "ch1 fault direction", v & 32'h2, 32'h2);
    rd(5'd14, v); chk("R8", "ch1 count unadvanced", v, 32'd4);
    rd(5'd13, v); chk("R8", "ch1 dst unadvanced", v, 32'h2800);
    wr(5'd16, 32'h0);
    chk("R7", "writing zero keeps flag", 32'(irq), 32'h8);
    wr(5'd16, 32'h8);
    chk("R7", "write-one clears", 32'(irq), 32'h0);

    // R8 read-side fault on ch0
    wr(5'd1, 32'h0000_2880);
    wr(5'd3, 32'd3);
    wr(5'd0, 32'h0000_100C);
    wait_idle(0);
    chk("R8", "read error flag", 32'(irq), 32'h4);
    rd(5'd7, v);  chk("R8", "ch0 fault address", v, 32'h2880);
    rd(5'd18, v); chk("R8", "ch0 fault direction", v & 32'h1, 32'h0);
    rd(5'd4, v);  chk("R8", "ch0 src unadvanced", v, 32'h2880);
    flt_en = 1'b0;
    wr(5'd16, 32'hF);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule